// File: doc/BRIEF.md
# DMA Descriptor Fetch Engine

This block walks a chain of DMA descriptors held in memory. It reads each descriptor one 16-bit word at a time through a simple request/valid read port. It loads the fields into the working registers of a channel and launches the transfer. When the transfer sequencer reports completion, the block either follows the chain to the next descriptor or returns to idle. Software starts a chain by pulsing `start` with the address of the first descriptor and a layout code.

Three chaining layouts are supported. In the packed layout, descriptors sit one after another in memory and carry no link words. In the paged layout, one link word gives the low half of the next address, and the high half comes from `page_hi`. In the wide layout, two link words give a full 32-bit next address. A count field in the control word sets how many of the four 2D geometry words follow it, so a short descriptor costs fewer reads. If a descriptor's enable bit is clear, the chain stalls until software pulses `restart`. A chain may point back to its own head and so run continuously.

Top module: `desc_fetch_engine`

## Requirements
- R1: After reset, `busy`, `stalled`, `rd_req`, `xfer_start`, `desc_done` and `irq` are all low. A `start` pulse in idle begins fetching at `start_ptr` with the layout on `layout` (0 packed, 1 paged, 2 or 3 wide). `start` while busy and `restart` while not stalled have no effect.
- R2: `rd_req` stays high with `rd_addr` stable until `rd_valid` is seen. Each accepted read moves one 16-bit word. Addresses count 16-bit words.
- R3: A descriptor's words are read at consecutive addresses in this order: link words (paged and wide only), start address low, start address high, control word, then up to four geometry words in the order inner count, inner stride, outer count, outer stride. The number of geometry words is control bits [6:4], and any value above 4 acts as 4.
- R4: In packed layout no link word is read, and the next descriptor begins at the word right after the last word of the current one.
- R5: In paged layout one link word is read, and the next descriptor address is {`page_hi`, link word}.
- R6: In wide layout two link words are read, low half first, and the next address is {second word, first word}.
- R7: Geometry fields that a descriptor does not fetch keep the value loaded by an earlier descriptor.
- R8: If control bit 0 (enable) is 1, `xfer_start` pulses for one cycle with all fields valid. If it is 0, `stalled` rises and no read or launch happens until `restart`, which re-reads the same descriptor from its first word.
- R9: `xfer_done` while a transfer runs gives a one-cycle `desc_done`. `irq` pulses in the same cycle only if control bit 1 is set.
- R10: If control bit 2 (stop) is set, the engine goes idle after the transfer completes. Otherwise it fetches the next descriptor, and a chain that links back to its head runs without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layout | input | 2 | Chain layout, latched at start |
| page_hi | input | 16 | High address half for the paged layout |
| start | input | 1 | Begin a chain (idle only) |
| start_ptr | input | 32 | Address of the first descriptor |
| restart | input | 1 | Resume a stalled chain |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 32 | Word address of the read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data word |
| xfer_start | output | 1 | Launch pulse to the transfer sequencer |
| xfer_addr | output | 32 | Transfer start address |
| xfer_cfg | output | 16 | Control word of the current descriptor |
| x_count | output | 16 | Inner count |
| x_stride | output | 16 | Inner stride |
| y_count | output | 16 | Outer count |
| y_stride | output | 16 | Outer stride |
| xfer_done | input | 1 | Transfer completion from the sequencer |
| desc_done | output | 1 | Descriptor completed pulse |
| irq | output | 1 | Completion interrupt pulse |
| busy | output | 1 | Chain active |
| stalled | output | 1 | Waiting for restart |

## Verification
The assertions check on every cycle that a read request is held with a steady address until it is answered. They also check that a launch never happens with the enable bit clear, that an interrupt only comes with a completion whose control word allows it, that a stalled or idle engine issues nothing, and that a stall is left only after a restart. The bench scenarios are needed to show the address sequences of each layout and the geometry word count limit. They also show that fields are kept across short descriptors, that the same descriptor is re-read after a restart, and that a looped chain keeps running.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  localparam int WW        = 16;
  localparam int AW        = 2 * WW;
  localparam int MAX_GEOM  = 4;
  localparam int IDX_W     = 4;
  localparam int NSLOT     = 9;

  localparam int CFG_EN     = 0;
  localparam int CFG_IRQ    = 1;
  localparam int CFG_STOP   = 2;
  localparam int CFG_NG_LSB = 4;
  localparam int CFG_NG_W   = 3;

  typedef enum logic [1:0] {
    LAY_PACKED = 2'd0,
    LAY_PAGED  = 2'd1,
    LAY_WIDE   = 2'd2,
    LAY_WIDE2  = 2'd3
  } layout_e;

  typedef enum logic [3:0] {
    SL_LNK_LO = 4'd0,
    SL_LNK_HI = 4'd1,
    SL_SA_LO  = 4'd2,
    SL_SA_HI  = 4'd3,
    SL_CTRL   = 4'd4,
    SL_XCNT   = 4'd5,
    SL_XSTR   = 4'd6,
    SL_YCNT   = 4'd7,
    SL_YSTR   = 4'd8
  } slot_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_DECIDE = 3'd2,
    ST_STALL  = 3'd3,
    ST_RUN    = 3'd4
  } state_e;

  // number of link words for a layout
  function automatic logic [1:0] link_words(layout_e lay);
    case (lay)
      LAY_PACKED: return 2'd0;
      LAY_PAGED:  return 2'd1;
      default:    return 2'd2;
    endcase
  endfunction

  // geometry words requested by a control word, clipped to MAX_GEOM
  function automatic logic [2:0] geom_words(logic [WW-1:0] ctrl);
    logic [CFG_NG_W-1:0] ng;
    ng = ctrl[CFG_NG_LSB +: CFG_NG_W];
    return (ng > 3'(MAX_GEOM)) ? 3'(MAX_GEOM) : ng;
  endfunction

  // total descriptor length in words
  function automatic logic [IDX_W-1:0] desc_len(layout_e lay, logic [WW-1:0] ctrl);
    return IDX_W'(link_words(lay)) + IDX_W'(3) + IDX_W'(geom_words(ctrl));
  endfunction

  // which field a word position fills
  function automatic slot_e slot_of(layout_e lay, logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] np;
    logic [IDX_W-1:0] k;
    np = IDX_W'(link_words(lay));
    if (idx < np) return (idx == '0) ? SL_LNK_LO : SL_LNK_HI;
    k = idx - np;
    case (k)
      4'd0:    return SL_SA_LO;
      4'd1:    return SL_SA_HI;
      4'd2:    return SL_CTRL;
      4'd3:    return SL_XCNT;
      4'd4:    return SL_XSTR;
      4'd5:    return SL_YCNT;
      default: return SL_YSTR;
    endcase
  endfunction

  // address of the following descriptor
  function automatic logic [AW-1:0] next_desc(layout_e lay, logic [AW-1:0] cur,
                                               logic [IDX_W-1:0] len, logic [WW-1:0] page,
                                               logic [WW-1:0] lo, logic [WW-1:0] hi);
    case (lay)
      LAY_PACKED: return cur + AW'(len);
      LAY_PAGED:  return {page, lo};
      default:    return {hi, lo};
    endcase
  endfunction

endpackage

// File: rtl/dfe_mem_port.sv
module dfe_mem_port
  import dfe_pkg::*;
(
  input  logic          fetch_active,
  input  logic [AW-1:0] word_addr,
  input  logic          rd_valid,
  input  logic [WW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          word_take,
  output logic [WW-1:0] word_val
);

  assign rd_req    = fetch_active;
  assign rd_addr   = word_addr;
  assign word_take = fetch_active && rd_valid;
  assign word_val  = rd_data;

endmodule

// File: rtl/dfe_field_bank.sv
module dfe_field_bank
  import dfe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_take,
  input  slot_e         slot,
  input  logic [WW-1:0] word_val,
  output logic [WW-1:0] lnk_lo,
  output logic [WW-1:0] lnk_hi,
  output logic [AW-1:0] start_addr,
  output logic [WW-1:0] ctrl,
  output logic [WW-1:0] xcnt,
  output logic [WW-1:0] xstr,
  output logic [WW-1:0] ycnt,
  output logic [WW-1:0] ystr
);

  logic [WW-1:0] fld [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                fld[s] <= '0;
      else if (word_take && (slot == slot_e'(s))) fld[s] <= word_val;
    end
  end

  assign lnk_lo     = fld[SL_LNK_LO];
  assign lnk_hi     = fld[SL_LNK_HI];
  assign start_addr = {fld[SL_SA_HI], fld[SL_SA_LO]};
  assign ctrl       = fld[SL_CTRL];
  assign xcnt       = fld[SL_XCNT];
  assign xstr       = fld[SL_XSTR];
  assign ycnt       = fld[SL_YCNT];
  assign ystr       = fld[SL_YSTR];

endmodule

// File: rtl/dfe_seq.sv
module dfe_seq
  import dfe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    layout,
  input  logic [WW-1:0] page_hi,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic          restart,
  input  logic          word_take,
  input  logic [WW-1:0] word_val,
  input  logic [WW-1:0] ctrl_q,
  input  logic [WW-1:0] lnk_lo,
  input  logic [WW-1:0] lnk_hi,
  input  logic          xfer_done,
  output logic          fetch_active,
  output logic [AW-1:0] word_addr,
  output slot_e         slot,
  output logic          xfer_start,
  output logic          desc_done,
  output logic          irq,
  output logic          busy,
  output logic          stalled
);

  state_e           st;
  layout_e          lay_q;
  logic [AW-1:0]    cur_ptr;
  logic [IDX_W-1:0] idx;

  // named internal events
  logic [WW-1:0]    ctrl_eff;
  logic [IDX_W-1:0] len_live;
  logic [IDX_W-1:0] len_cur;
  logic             last_word;
  logic [AW-1:0]    next_ptr_w;
  logic             chain_end;

  assign slot       = slot_of(lay_q, idx);
  assign ctrl_eff   = (slot == SL_CTRL) ? word_val : ctrl_q;
  assign len_live   = desc_len(lay_q, ctrl_eff);
  assign len_cur    = desc_len(lay_q, ctrl_q);
  assign last_word  = word_take && ((idx + 1'b1) == len_live);
  assign next_ptr_w = next_desc(lay_q, cur_ptr, len_cur, page_hi, lnk_lo, lnk_hi);
  assign chain_end  = ctrl_q[CFG_STOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lay_q   <= LAY_PACKED;
      cur_ptr <= '0;
      idx     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur_ptr <= start_ptr;
          lay_q   <= layout_e'(layout);
          idx     <= '0;
          st      <= ST_FETCH;
        end
        ST_FETCH: if (word_take) begin
          if (last_word) st  <= ST_DECIDE;
          else           idx <= idx + 1'b1;
        end
        ST_DECIDE: st <= ctrl_q[CFG_EN] ? ST_RUN : ST_STALL;
        ST_STALL: if (restart) begin
          idx <= '0;
          st  <= ST_FETCH;
        end
        ST_RUN: if (xfer_done) begin
          if (chain_end) st <= ST_IDLE;
          else begin
            cur_ptr <= next_ptr_w;
            idx     <= '0;
            st      <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign fetch_active = (st == ST_FETCH);
  assign word_addr    = cur_ptr + AW'(idx);
  assign xfer_start   = (st == ST_DECIDE) && ctrl_q[CFG_EN];
  assign desc_done    = (st == ST_RUN) && xfer_done;
  assign irq          = desc_done && ctrl_q[CFG_IRQ];
  assign busy         = (st != ST_IDLE);
  assign stalled      = (st == ST_STALL);

endmodule

// File: rtl/desc_fetch_engine.sv
module desc_fetch_engine
  import dfe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    layout,
  input  logic [WW-1:0] page_hi,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic          restart,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [WW-1:0] rd_data,
  output logic          xfer_start,
  output logic [AW-1:0] xfer_addr,
  output logic [WW-1:0] xfer_cfg,
  output logic [WW-1:0] x_count,
  output logic [WW-1:0] x_stride,
  output logic [WW-1:0] y_count,
  output logic [WW-1:0] y_stride,
  input  logic          xfer_done,
  output logic          desc_done,
  output logic          irq,
  output logic          busy,
  output logic          stalled
);

  logic          fetch_active;
  logic [AW-1:0] word_addr;
  logic          word_take;
  logic [WW-1:0] word_val;
  slot_e         slot;
  logic [WW-1:0] lnk_lo;
  logic [WW-1:0] lnk_hi;

  dfe_mem_port port_i (
    .fetch_active (fetch_active),
    .word_addr    (word_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .word_take    (word_take),
    .word_val     (word_val)
  );

  dfe_field_bank bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_take  (word_take),
    .slot       (slot),
    .word_val   (word_val),
    .lnk_lo     (lnk_lo),
    .lnk_hi     (lnk_hi),
    .start_addr (xfer_addr),
    .ctrl       (xfer_cfg),
    .xcnt       (x_count),
    .xstr       (x_stride),
    .ycnt       (y_count),
    .ystr       (y_stride)
  );

  dfe_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .layout       (layout),
    .page_hi      (page_hi),
    .start        (start),
    .start_ptr    (start_ptr),
    .restart      (restart),
    .word_take    (word_take),
    .word_val     (word_val),
    .ctrl_q       (xfer_cfg),
    .lnk_lo       (lnk_lo),
    .lnk_hi       (lnk_hi),
    .xfer_done    (xfer_done),
    .fetch_active (fetch_active),
    .word_addr    (word_addr),
    .slot         (slot),
    .xfer_start   (xfer_start),
    .desc_done    (desc_done),
    .irq          (irq),
    .busy         (busy),
    .stalled      (stalled)
  );

endmodule

// File: rtl/dfe_checker.sv
module dfe_checker
  import dfe_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          xfer_start,
  input logic [WW-1:0] xfer_cfg,
  input logic          desc_done,
  input logic          irq,
  input logic          busy,
  input logic          stalled,
  input logic          restart
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R2

  AST_LAUNCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> xfer_cfg[CFG_EN]); // R8

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !rd_req && !xfer_start && !desc_done); // R8

  AST_STALL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stalled) |-> $past(restart)); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> desc_done && xfer_cfg[CFG_IRQ]); // R9

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, xfer_start, desc_done})); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !stalled && !xfer_start); // R1

endmodule

bind desc_fetch_engine dfe_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .xfer_start (xfer_start),
  .xfer_cfg   (xfer_cfg),
  .desc_done  (desc_done),
  .irq        (irq),
  .busy       (busy),
  .stalled    (stalled),
  .restart    (restart)
);

// File: tb/desc_fetch_engine_tb_top.sv
`timescale 1ns/1ps
module desc_fetch_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  layout = 2'd0;
  logic [15:0] page_hi = 16'h0;
  logic        start = 1'b0;
  logic [31:0] start_ptr = 32'h0;
  logic        restart = 1'b0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        xfer_start;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_cfg, x_count, x_stride, y_count, y_stride;
  logic        xfer_done;
  logic        desc_done, irq, busy, stalled;

  int errors = 0;
  int checks = 0;
  int mem_lat = 0;

  logic [15:0] mem [0:1023];

  always #10 clk = ~clk;

  desc_fetch_engine dut_i (
    .clk(clk), .rst_n(rst_n), .layout(layout), .page_hi(page_hi),
    .start(start), .start_ptr(start_ptr), .restart(restart),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_cfg(xfer_cfg),
    .x_count(x_count), .x_stride(x_stride), .y_count(y_count), .y_stride(y_stride),
    .xfer_done(xfer_done), .desc_done(desc_done), .irq(irq),
    .busy(busy), .stalled(stalled)
  );

  // memory model with programmable latency
  int lat_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= 16'h0; lat_cnt <= 0;
    end else if (rd_req && !rd_valid) begin
      if (lat_cnt >= mem_lat) begin
        rd_valid <= 1'b1; rd_data <= mem[rd_addr[9:0]]; lat_cnt <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else rd_valid <= 1'b0;
  end

  // transfer sequencer model: completes three cycles after launch
  int xf_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xf_cnt <= 0; xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      if (xfer_start) xf_cnt <= 3;
      else if (xf_cnt > 0) begin
        if (xf_cnt == 1) xfer_done <= 1'b1;
        xf_cnt <= xf_cnt - 1;
      end
    end
  end

  // monitors
  logic [31:0] rlog [0:63];
  logic [31:0] l_addr [0:15];
  logic [15:0] l_xc [0:15];
  logic [15:0] l_ys [0:15];
  logic        irq_at [0:15];
  int rcount, lc, dc, ic;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcount <= 0; lc <= 0; dc <= 0; ic <= 0;
    end else begin
      if (rd_req && rd_valid) begin
        if (rcount < 64) rlog[rcount] <= rd_addr;
        rcount <= rcount + 1;
      end
      if (xfer_start) begin
        if (lc < 16) begin
          l_addr[lc] <= xfer_addr; l_xc[lc] <= x_count; l_ys[lc] <= y_stride;
        end
        lc <= lc + 1;
      end
      if (desc_done) begin
        if (dc < 16) irq_at[dc] <= irq;
        dc <= dc + 1;
      end
      if (irq) ic <= ic + 1;
    end
  end

  function automatic logic [15:0] mkctrl(bit en, bit ie, bit stp, int ng);
    return {9'b0, 3'(ng), 1'b0, stp, ie, en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; restart = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic kick(input logic [31:0] ptr, input logic [1:0] lay);
    @(negedge clk);
    start = 1'b1; start_ptr = ptr; layout = lay;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 busy after reset", busy, 0);
    check("R1 rd_req after reset", rd_req, 0);
    check("R1 stalled after reset", stalled, 0);
    check("R1 outputs quiet", {xfer_start, desc_done, irq}, 0);
    pulse_restart();
    repeat (5) @(negedge clk);
    check("R1 restart in idle ignored", {busy, rd_req}, 0);
  endtask

  task automatic test_packed();
    do_reset(); mem_lat = 1;
    mem[10'h100] = 16'h1111; mem[10'h101] = 16'h2222; mem[10'h102] = mkctrl(1,1,0,4);
    mem[10'h103] = 16'h0010; mem[10'h104] = 16'h0004; mem[10'h105] = 16'h0002; mem[10'h106] = 16'h0020;
    mem[10'h107] = 16'h3333; mem[10'h108] = 16'h4444; mem[10'h109] = mkctrl(1,0,1,0);
    kick(32'h0000_0100, 2'd0);
    wait_idle();
    check("R4 packed read count", rcount, 10);
    for (int i = 0; i < 10; i++) check("R3 R4 packed address order", rlog[i], 32'h100 + i);
    check("R8 packed launches", lc, 2);
    check("R3 start address assembly", l_addr[0], 32'h2222_1111);
    check("R3 inner count field", l_xc[0], 16'h0010);
    check("R3 outer stride field", l_ys[0], 16'h0020);
    check("R8 second start address", l_addr[1], 32'h4444_3333);
    check("R7 inner count kept", l_xc[1], 16'h0010);
    check("R7 outer stride kept", l_ys[1], 16'h0020);
    check("R9 completions", dc, 2);
    check("R9 interrupt count", ic, 1);
    check("R9 irq on first", irq_at[0], 1);
    check("R9 no irq on second", irq_at[1], 0);
    check("R10 idle after stop", busy, 0);
  endtask

  task automatic test_paged();
    do_reset(); mem_lat = 0; page_hi = 16'h0012;
    mem[10'h040] = 16'h0080; mem[10'h041] = 16'h5555; mem[10'h042] = 16'h6666;
    mem[10'h043] = mkctrl(1,0,0,2); mem[10'h044] = 16'h0008; mem[10'h045] = 16'h0002;
    mem[10'h080] = 16'hFFFF; mem[10'h081] = 16'h7777; mem[10'h082] = 16'h8888;
    mem[10'h083] = mkctrl(1,1,1,5);
    mem[10'h084] = 16'h0001; mem[10'h085] = 16'h0002; mem[10'h086] = 16'h0003; mem[10'h087] = 16'h0004;
    mem[10'h088] = 16'hDEAD;
    kick(32'h0012_0040, 2'd1);
    wait_idle();
    check("R1 first read at start_ptr", rlog[0], 32'h0012_0040);
    check("R5 next descriptor in page", rlog[6], 32'h0012_0080);
    check("R3 geometry count clipped to 4", rcount, 14);
    check("R3 last word read", rlog[13], 32'h0012_0087);
    check("R5 paged launch address", l_addr[1], 32'h8888_7777);
    check("R3 inner count second", l_xc[1], 16'h0001);
    check("R3 outer stride second", l_ys[1], 16'h0004);
    check("R9 irq on second only", ic, 1);
    check("R9 irq flag second", irq_at[1], 1);
  endtask

  task automatic test_wide();
    do_reset(); mem_lat = 2;
    mem[10'h200] = 16'h0300; mem[10'h201] = 16'h0005; mem[10'h202] = 16'h9999;
    mem[10'h203] = 16'hAAAA; mem[10'h204] = mkctrl(1,0,0,0);
    mem[10'h300] = 16'h0; mem[10'h301] = 16'h0; mem[10'h302] = 16'hBBBB;
    mem[10'h303] = 16'hCCCC; mem[10'h304] = mkctrl(1,0,1,1); mem[10'h305] = 16'h0042;
    kick(32'h0003_0200, 2'd2);
    wait_idle();
    check("R6 wide read count", rcount, 11);
    check("R6 wide second link word", rlog[1], 32'h0003_0201);
    check("R6 wide next address", rlog[5], 32'h0005_0300);
    check("R6 wide first launch", l_addr[0], 32'h AAAA_9999);
    check("R6 wide second launch", l_addr[1], 32'hCCCC_BBBB);
    check("R3 wide inner count", l_xc[1], 16'h0042);
  endtask

  task automatic test_stall();
    do_reset(); mem_lat = 0;
    mem[10'h140] = 16'h0101; mem[10'h141] = 16'h0202; mem[10'h142] = mkctrl(0,1,1,0);
    kick(32'h0000_0140, 2'd0);
    repeat (30) @(negedge clk);
    check("R8 stalled on clear enable", stalled, 1);
    check("R8 no launch while stalled", lc, 0);
    check("R8 reads stop at stall", rcount, 3);
    kick(32'h0000_0300, 2'd0);
    repeat (10) @(negedge clk);
    check("R1 start while busy ignored", rcount, 3);
    check("R8 still stalled", stalled, 1);
    mem[10'h142] = mkctrl(1,1,1,0);
    pulse_restart();
    wait_idle();
    check("R8 refetch after restart", rcount, 6);
    check("R8 refetch from first word", rlog[3], 32'h0000_0140);
    check("R8 launch after restart", lc, 1);
    check("R8 launch address", l_addr[0], 32'h0202_0101);
    check("R9 irq after restart", ic, 1);
    check("R8 stall cleared", stalled, 0);
  endtask

  task automatic test_loop();
    do_reset(); mem_lat = 0; page_hi = 16'h0012;
    mem[10'h010] = 16'h0020; mem[10'h011] = 16'hA0A0; mem[10'h012] = 16'h0000; mem[10'h013] = mkctrl(1,1,0,0);
    mem[10'h020] = 16'h0010; mem[10'h021] = 16'hB0B0; mem[10'h022] = 16'h0000; mem[10'h023] = mkctrl(1,0,0,0);
    kick(32'h0012_0010, 2'd1);
    for (int i = 0; i < 3000 && dc < 5; i++) @(negedge clk);
    check("R10 loop completions", dc >= 5, 1);
    check("R10 loop returns to head", rlog[8], 32'h0012_0010);
    check("R10 loop alternates", l_addr[2], 32'h0000_A0A0);
    check("R10 loop second desc", l_addr[1], 32'h0000_B0B0);
    check("R9 irq on head only", ic, 3);
    check("R10 still busy", busy, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_packed();
    test_paged();
    test_wide();
    test_stall();
    test_loop();
    do_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule